// File: doc/BRIEF.md
# Descriptor-Driven Copy and Parity Engine

This block runs one transfer descriptor at a time against a word-addressed memory port. A descriptor is a 32-bit control word, a byte length, a source byte address, a destination byte address and a packed list of up to eight data-buffer byte addresses. The control word selects one of three operations: an idle descriptor that only signals completion, a plain copy from the source address to the destination address, and a parity build in which every destination word is the XOR of the words at the same offset in each active data buffer.

The engine streams the data one word at a time. For each destination offset it reads the active sources in index order through the memory port, folds each returned word into an accumulator, and then writes the accumulated word once. When the descriptor finishes, a one-cycle completion strobe is raised, together with an error flag for rejected descriptors and an interrupt flag when the descriptor asked for one. Descriptors that cannot be run are rejected at once, without touching memory.

Top module: `xor_dma_engine`

## Requirements
- R1: The operation code sits in control bits [31:28]; code 1 is a copy that moves `len` bytes (len/4 words) from the source address to the destination address, word by word in ascending order.
- R2: Code 6 is a parity build; the source count sits in control bits [25:22] and must be 1 to 8, and control bit 17 (parity output enable) must be set; each destination word equals the XOR of the words at the same word offset in every active data buffer, read in buffer index order before the single write of that word.
- R3: Data-buffer addresses arrive as twelve 32-bit words, three per pair of buffers: word 3p holds the low 32 bits of buffer 2p, word 3p+1 the low 32 bits of buffer 2p+1, and word 3p+2 the upper 16 bits of buffer 2p in [15:0] and of buffer 2p+1 in [31:16].
- R4: Code 0 is an idle descriptor: it completes with no memory access and no error, whatever its length.
- R5: Control bit 27 requests an interrupt: `irq_o` is high together with the completion strobe exactly when that bit was set in the finished descriptor.
- R6: Codes 2, 3, 4, 5, 7 and 8 to 15 are unsupported: the descriptor completes with the error flag set and no memory access.
- R7: A parity build with a source count of 0 or above 8, or with control bit 17 clear, completes with the error flag set and no memory access.
- R8: For a copy or parity build, a length whose low two bits are not zero completes with the error flag set and no memory access; a length of zero completes without error and without memory access.
- R9: A start request while the engine is busy is ignored and leaves the running descriptor and the memory unaffected.
- R10: The completion strobe is high for exactly one cycle per accepted descriptor, never while busy; the error and interrupt flags are high only together with it.
- R11: A memory request holds its address, direction and write data until it is granted; read data is taken on the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Descriptor launch request |
| ctrl_i | input | 32 | Control word (operation, count, enables) |
| len_i | input | LEN_W | Transfer length in bytes |
| src_i | input | 48 | Copy source byte address |
| dst_i | input | 48 | Destination byte address |
| bufw_i | input | 32*3*((MAX_SRC+1)/2) | Packed data-buffer addresses |
| busy_o | output | 1 | Descriptor in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Descriptor rejected (with done) |
| irq_o | output | 1 | Interrupt request (with done) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request granted this cycle |
| mem_rdata_i | input | 32 | Read data, one cycle after a granted read |

## Verification
The bench builds the engine with ADDR_W=10, LEN_W=8 and MAX_SRC=8, so a 1024-word memory model holds all eight source regions, a copy source and two destination regions at once, and a descriptor of up to 63 words fits the length field. With eight sources available the full parity fan-in and the out-of-range count of nine are both reachable, and the narrow length keeps the longest stream to sixteen words while a grant that drops every third cycle stresses the request hold and the read-latency timing.

// File: rtl/xeng_pkg.sv
package xeng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_LAT,
    ST_WR
  } eng_state_e;

  typedef enum logic [1:0] {
    K_IDLE,
    K_COPY,
    K_PARITY,
    K_BAD
  } op_kind_e;

  localparam logic [3:0] OPC_IDLE   = 4'd0;
  localparam logic [3:0] OPC_COPY   = 4'd1;
  localparam logic [3:0] OPC_PARITY = 4'd6;

  localparam int OP_LSB   = 28;
  localparam int IRQ_BIT  = 27;
  localparam int CNT_LSB  = 22;
  localparam int PEN_BIT  = 17;

endpackage

// File: rtl/xeng_decode.sv
module xeng_decode
  import xeng_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_SRC = 8
) (
  input  logic [31:0]      ctrl_i,
  input  logic [LEN_W-1:0] len_i,
  output op_kind_e         kind_o,
  output logic             err_o,
  output logic             ioc_o,
  output logic             empty_o,
  output logic [3:0]       nsrc_o
);

  logic [3:0] opc;
  logic       pen;
  logic       ragged;

  always_comb begin
    opc     = ctrl_i[OP_LSB +: 4];
    nsrc_o  = ctrl_i[CNT_LSB +: 4];
    pen     = ctrl_i[PEN_BIT];
    ioc_o   = ctrl_i[IRQ_BIT];
    ragged  = (len_i[1:0] != 2'b00);
    empty_o = (len_i[LEN_W-1:2] == '0);

    unique case (opc)
      OPC_IDLE: kind_o = K_IDLE;
      OPC_COPY: kind_o = K_COPY;
      OPC_PARITY: begin
        if (pen && (nsrc_o != 4'd0) && (32'(nsrc_o) <= MAX_SRC))
          kind_o = K_PARITY;
        else
          kind_o = K_BAD;
      end
      default: kind_o = K_BAD;
    endcase

    err_o = (kind_o == K_BAD) || ((kind_o != K_IDLE) && ragged);
  end

endmodule

// File: rtl/xeng_bufaddr.sv
module xeng_bufaddr #(
  parameter int ADDR_W  = 16,
  parameter int MAX_SRC = 8,
  localparam int NPAIR  = (MAX_SRC + 1) / 2,
  localparam int NWORD  = NPAIR * 3
) (
  input  logic [32*NWORD-1:0]      words_i,
  output logic [MAX_SRC*ADDR_W-1:0] waddr_o
);

  for (genvar i = 0; i < MAX_SRC; i++) begin : g_buf
    localparam int LOW_IDX = (i / 2) * 3 + (i % 2);
    localparam int HI_IDX  = (i / 2) * 3 + 2;
    localparam int HI_LSB  = (i % 2) * 16;
    logic [47:0] byte_addr;
    always_comb begin
      byte_addr = {words_i[HI_IDX*32 + HI_LSB +: 16], words_i[LOW_IDX*32 +: 32]};
      waddr_o[i*ADDR_W +: ADDR_W] = byte_addr[ADDR_W+1:2];
    end
  end

endmodule

// File: rtl/xor_dma_engine.sv
module xor_dma_engine
  import xeng_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int MAX_SRC = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_i,
  input  logic [31:0]                      ctrl_i,
  input  logic [LEN_W-1:0]                 len_i,
  input  logic [47:0]                      src_i,
  input  logic [47:0]                      dst_i,
  input  logic [32*3*((MAX_SRC+1)/2)-1:0]  bufw_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic                             err_o,
  output logic                             irq_o,
  output logic                             mem_req_o,
  output logic                             mem_we_o,
  output logic [ADDR_W-1:0]                mem_addr_o,
  output logic [31:0]                      mem_wdata_o,
  input  logic                             mem_gnt_i,
  input  logic [31:0]                      mem_rdata_i
);

  localparam int SRC_W  = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1;
  localparam int WCNT_W = LEN_W - 2;

  eng_state_e          state_q;
  op_kind_e            dec_kind;
  logic                dec_err, dec_ioc, dec_empty;
  logic [3:0]          dec_nsrc;
  logic [MAX_SRC*ADDR_W-1:0] unpacked;

  logic [ADDR_W-1:0]   base_q [MAX_SRC];
  logic [ADDR_W-1:0]   src_q, dst_q;
  logic                copy_q, ioc_q;
  logic [SRC_W-1:0]    k_q, klast_q;
  logic [WCNT_W-1:0]   w_q, wlast_q;
  logic [31:0]         acc_q;
  logic                done_q, err_q, irq_q;
  logic [ADDR_W-1:0]   rd_base;
  logic [31:0]         folded;

  xeng_decode #(.LEN_W(LEN_W), .MAX_SRC(MAX_SRC)) u_dec (
    .ctrl_i (ctrl_i),
    .len_i  (len_i),
    .kind_o (dec_kind),
    .err_o  (dec_err),
    .ioc_o  (dec_ioc),
    .empty_o(dec_empty),
    .nsrc_o (dec_nsrc)
  );

  xeng_bufaddr #(.ADDR_W(ADDR_W), .MAX_SRC(MAX_SRC)) u_buf (
    .words_i(bufw_i),
    .waddr_o(unpacked)
  );

  always_comb begin
    rd_base     = copy_q ? src_q : base_q[k_q];
    folded      = (k_q == '0) ? mem_rdata_i : (acc_q ^ mem_rdata_i);
    mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
    mem_we_o    = (state_q == ST_WR);
    mem_addr_o  = (state_q == ST_WR) ? (dst_q + ADDR_W'(w_q)) : (rd_base + ADDR_W'(w_q));
    mem_wdata_o = acc_q;
    busy_o      = (state_q != ST_IDLE);
    done_o      = done_q;
    err_o       = err_q;
    irq_o       = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      copy_q  <= 1'b0;
      ioc_q   <= 1'b0;
      k_q     <= '0;
      klast_q <= '0;
      w_q     <= '0;
      wlast_q <= '0;
      acc_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      for (int i = 0; i < MAX_SRC; i++) base_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (dec_err || dec_kind == K_IDLE || dec_empty) begin
              done_q <= 1'b1;
              err_q  <= dec_err;
              irq_q  <= dec_ioc;
            end else begin
              state_q <= ST_RD;
              copy_q  <= (dec_kind == K_COPY);
              ioc_q   <= dec_ioc;
              k_q     <= '0;
              klast_q <= (dec_kind == K_COPY) ? '0 : SRC_W'(dec_nsrc - 4'd1);
              w_q     <= '0;
              wlast_q <= len_i[LEN_W-1:2] - 1'b1;
              src_q   <= src_i[ADDR_W+1:2];
              dst_q   <= dst_i[ADDR_W+1:2];
              for (int i = 0; i < MAX_SRC; i++)
                base_q[i] <= unpacked[i*ADDR_W +: ADDR_W];
            end
          end
        end
        ST_RD: begin
          if (mem_gnt_i) state_q <= ST_LAT;
        end
        ST_LAT: begin
          acc_q <= folded;
          if (k_q == klast_q) begin
            state_q <= ST_WR;
          end else begin
            k_q     <= k_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_WR: begin
          if (mem_gnt_i) begin
            k_q <= '0;
            if (w_q == wlast_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              irq_q   <= ioc_q;
            end else begin
              w_q     <= w_q + 1'b1;
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xeng_chk.sv
module xeng_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              irq_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_gnt_i
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_we_o)
                                   && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_flags_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    (err_o || irq_o) |-> done_o);

  p_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o || done_o));

  p_no_err_access_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> !(done_o && mem_req_o));

endmodule

bind xor_dma_engine xeng_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .irq_o      (irq_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_gnt_i  (mem_gnt_i)
);

// File: tb/sim_xor_dma_engine.sv
`timescale 1ns/1ps
module sim_xor_dma_engine;
  localparam int ADDR_W  = 10;
  localparam int LEN_W   = 8;
  localparam int MAX_SRC = 8;
  localparam int BW      = 32 * 3 * ((MAX_SRC + 1) / 2);
  localparam int DST0    = 512;
  localparam int DST1    = 600;
  localparam int CPYSRC  = 400;

  // row: [31:28] op, [27:24] count, [23] parity enable, [22] irq, [21] expect error, [15:0] length
  localparam logic [31:0] VEC [13] = '{
    {4'd1, 4'd0, 1'b0, 1'b1, 1'b0, 5'd0, 16'd16},
    {4'd6, 4'd1, 1'b1, 1'b0, 1'b0, 5'd0, 16'd8},
    {4'd6, 4'd3, 1'b1, 1'b1, 1'b0, 5'd0, 16'd20},
    {4'd6, 4'd8, 1'b1, 1'b0, 1'b0, 5'd0, 16'd64},
    {4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 5'd0, 16'd32},
    {4'd6, 4'd0, 1'b1, 1'b0, 1'b1, 5'd0, 16'd16},
    {4'd6, 4'd9, 1'b1, 1'b1, 1'b1, 5'd0, 16'd16},
    {4'd5, 4'd1, 1'b1, 1'b0, 1'b1, 5'd0, 16'd16},
    {4'd6, 4'd2, 1'b1, 1'b0, 1'b1, 5'd0, 16'd6},
    {4'd6, 4'd2, 1'b0, 1'b0, 1'b1, 5'd0, 16'd16},
    {4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 5'd0, 16'd0},
    {4'd8, 4'd2, 1'b1, 1'b0, 1'b1, 5'd0, 16'd8},
    {4'd6, 4'd2, 1'b1, 1'b1, 1'b0, 5'd0, 16'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [47:0] src_i = '0, dst_i = '0;
  logic [BW-1:0] bufw_i = '0;
  logic busy_o, done_o, err_o, irq_o, mem_req_o, mem_we_o, mem_gnt_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  logic [31:0] mem [1024];
  int unsigned cyc = 0;
  int unsigned acc_cnt = 0;
  int unsigned done_cnt = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xor_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_SRC(MAX_SRC)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .ctrl_i(ctrl_i), .len_i(len_i),
    .src_i(src_i), .dst_i(dst_i), .bufw_i(bufw_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .irq_o(irq_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
    .mem_rdata_i(mem_rdata_i)
  );

  initial mem_gnt_i = 1'b0;
  initial mem_rdata_i = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_gnt_i <= ((cyc % 3) != 1);
  end

  always @(posedge clk) begin
    if (done_o) done_cnt <= done_cnt + 1;
    if (mem_req_o && mem_gnt_i) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else mem_rdata_i <= mem[mem_addr_o];
    end
  end

  function automatic logic [31:0] srcval(int k, int i);
    return 32'h9E3779B9 * 32'(k + 1) + 32'(i) * 32'h01000193;
  endfunction

  function automatic logic [31:0] cpyval(int i);
    return 32'hC0DE0000 + 32'(i);
  endfunction

  function automatic logic [BW-1:0] mkbuf();
    logic [BW-1:0] b = '0;
    for (int k = 0; k < MAX_SRC; k++) begin
      b[((k/2)*3 + (k%2))*32 +: 32] = 32'(128 * k);
      b[((k/2)*3 + 2)*32 + (k%2)*16 +: 16] = 16'(16'h0011 * k);
    end
    return b;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_dst(int base);
    for (int i = 0; i < 32; i++) mem[base + i] = 32'hDEAD0000 + 32'(i);
  endtask

  task automatic launch(logic [31:0] c, logic [LEN_W-1:0] l, int dbase);
    @(negedge clk);
    ctrl_i = c; len_i = l;
    src_i = 48'(CPYSRC * 4); dst_i = 48'(dbase * 4);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    int n = 0;
    got = 1'b0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (done_o) got = 1'b1;
    else check(1'b0, "R10 watchdog", 32'(n), 32'd3000);
  endtask

  initial begin
    bit got;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int k = 0; k < MAX_SRC; k++)
      for (int i = 0; i < 32; i++) mem[32*k + i] = srcval(k, i);
    for (int i = 0; i < 32; i++) mem[CPYSRC + i] = cpyval(i);
    bufw_i = mkbuf();

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !err_o && !irq_o, "R10 reset state",
          {27'd0, busy_o, done_o, mem_req_o, err_o, irq_o}, 32'd0);

    for (int r = 0; r < 13; r++) begin
      logic [31:0] row = VEC[r];
      logic [3:0] op = row[31:28];
      logic [3:0] n = row[27:24];
      logic ioc = row[22];
      logic xerr = row[21];
      int len = int'(row[15:0]);
      bit moves = !xerr && (op != 4'd0) && (len != 0);
      int nsrc = (op == 4'd1) ? 1 : int'(n);
      int nw = moves ? len / 4 : 0;
      logic [31:0] c = ({op, 28'd0}) | (32'(ioc) << 27) | (32'(n) << 22) | (32'(row[23]) << 17);
      int unsigned acc0;
      string tag;
      bit ok = 1'b1;
      logic [31:0] bad_act = '0, bad_exp = '0;

      if (op == 4'd1) tag = (len == 0) ? "R8" : "R1";
      else if (op == 4'd0) tag = "R4";
      else if (op != 4'd6) tag = "R6";
      else if (len % 4 != 0) tag = "R8";
      else if (xerr) tag = "R7";
      else tag = "R2";

      fill_dst(DST0);
      acc0 = acc_cnt;
      launch(c, row[LEN_W-1:0], DST0);
      wait_done(got);
      if (got) begin
        check(err_o == xerr, {tag, " error flag"}, 32'(err_o), 32'(xerr));
        check(irq_o == ioc, "R5 interrupt flag", 32'(irq_o), 32'(ioc));
        @(negedge clk);
        check(!done_o, "R10 done one cycle", 32'(done_o), 32'd0);
      end
      for (int i = 0; i < 32; i++) begin
        logic [31:0] e;
        if (i < nw) begin
          if (op == 4'd1) e = cpyval(i);
          else begin
            e = '0;
            for (int k = 0; k < nsrc; k++) e ^= srcval(k, i);
          end
        end else e = 32'hDEAD0000 + 32'(i);
        if (mem[DST0 + i] !== e && ok) begin
          ok = 1'b0; bad_act = mem[DST0 + i]; bad_exp = e;
        end
      end
      check(ok, (op == 4'd6 && !xerr) ? "R3 R2 destination" : {tag, " destination"}, bad_act, bad_exp);
      check(acc_cnt - acc0 == nw * (nsrc + 1), {tag, " access count R11"},
            32'(acc_cnt - acc0), 32'(nw * (nsrc + 1)));
    end

    // R9: second start during a busy parity build is ignored
    begin
      int d0;
      bit ok = 1'b1;
      fill_dst(DST0);
      fill_dst(DST1);
      d0 = int'(done_cnt);
      launch((32'd6 << 28) | (32'd2 << 22) | (32'd1 << 17), 8'd16, DST0);
      repeat (2) @(negedge clk);
      check(busy_o, "R9 busy during transfer", 32'(busy_o), 32'd1);
      launch((32'd1 << 28), 8'd16, DST1);
      wait_done(got);
      repeat (20) @(negedge clk);
      check(int'(done_cnt) - d0 == 1, "R9 single completion", 32'(int'(done_cnt) - d0), 32'd1);
      for (int i = 0; i < 4; i++)
        if (mem[DST0 + i] !== (srcval(0, i) ^ srcval(1, i))) ok = 1'b0;
      check(ok, "R9 running descriptor intact", mem[DST0], srcval(0, 0) ^ srcval(1, 0));
      check(mem[DST1] === 32'hDEAD0000, "R9 ignored copy left memory", mem[DST1], 32'hDEAD0000);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule